// File: doc/BRIEF.md
# Two-Phase Mailbox Command Responder

This block answers the mailbox commands arriving at the client end of a sideband management bus. The bus front end has already framed and checked each command; this block sees one decoded frame per cycle, carrying a command code, a read length and a write length, plus the request payload. A request is handed over by a send command and picked up later by a separate get command. Between the two, an internal worker, modelled here by a start pulse and a done strobe, produces the answer.

The responder holds one mailbox slot that is pending, ready or empty, and answers every frame with a one-cycle response strobe and a two-bit status. The three outcomes are: success with data, an abort (the frame is not understood, or the answer is not there yet and the get should be repeated), and a failed completion (there is nothing to collect). A watchdog discards a request that is never collected, unless a configuration input turns that discard off.

Top module: `mbox_responder`

## Requirements
- R1: The low two code bits select a domain: 2'b01 is domain 0 and 2'b10 is domain 1. 2'b00 and 2'b11 are unsupported. The upper six bits select the command: 6'h34 is send (codes 0xD1 and 0xD2) and 6'h35 is get (codes 0xD5 and 0xD6). Any unknown command or unsupported domain is answered with status 1 (abort) and changes no state.
- R2: A send must carry read length 1 and write length 7. A get must carry read length 5 and write length 1. A known code with any other length is answered with status 1 and leaves the mailbox untouched.
- R3: An accepted send answers status 0 with data 0. In the same cycle as the response it pulses `work_start` for one cycle, with `work_req` equal to the payload. It marks the slot pending, not ready, and owned by the send's domain.
- R4: A get from the owning domain while the worker's result is ready answers status 0, with `rsp_data` equal to the latched `work_result`, and empties the slot. A second get then answers status 2.
- R5: A get from the owning domain while the result is not yet ready answers status 1 and keeps the request pending, so that a repeated get succeeds once the result has arrived.
- R6: A get while no request is pending, or from the domain that does not own the pending request, answers status 2 (failed completion).
- R7: With the timeout enabled, a get accepted on the TIMEOUT_CYC-th clock edge after the send's edge still finds the request. From edge TIMEOUT_CYC+1 on, the request is discarded and a get answers status 2.
- R8: While `timeout_disable` is 1, a pending request is never discarded by time.
- R9: A send while a request is pending replaces it, drops its ready state and restarts the timeout count from zero.
- R10: `rsp_valid` is high exactly in the cycle after each cycle with `cmd_valid` high. `rsp_status` is never 3, and `rsp_data` is 0 unless the status is 0.
- R11: Synchronous active-high reset empties the slot, clears the timeout count and keeps `rsp_valid` and `work_start` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_disable | input | 1 | 1 turns off the automatic discard |
| cmd_valid | input | 1 | One decoded frame this cycle |
| cmd_code | input | CODE_W | Command code; low DOM_W bits are the domain |
| cmd_rd_len | input | LEN_W | Read length byte of the frame |
| cmd_wr_len | input | LEN_W | Write length byte of the frame |
| cmd_payload | input | DATA_W | Request payload of a send |
| rsp_valid | output | 1 | Response strobe, one cycle per frame |
| rsp_status | output | 2 | 0 success, 1 abort, 2 failed completion |
| rsp_data | output | DATA_W | Response data on success, else 0 |
| work_start | output | 1 | Pulse that starts the worker |
| work_req | output | DATA_W | Request handed to the worker |
| work_done | input | 1 | Worker result strobe |
| work_result | input | DATA_W | Worker result |

## Verification
The bench builds the responder with TIMEOUT_CYC set to 20 and keeps every length and width at its default. The short timeout places the exact expiry edge, a get one edge before it, and overwrites that restart the count within a few dozen cycles. It also makes expiry a frequent event during the random traffic. The worker latency in the bench varies from 1 to 8 cycles, so gets regularly land before the result is ready. This drives the abort-then-retry path, including retries that race the discard.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ABORT = 2'd1,
    ST_FAIL  = 2'd2
  } rsp_status_e;

  typedef enum logic [1:0] {
    CK_SEND = 2'd0,
    CK_GET  = 2'd1,
    CK_BAD  = 2'd2
  } cmd_kind_e;

  // Command bases with the domain bits zeroed.
  localparam logic [7:0] SEND_BASE = 8'hD0;
  localparam logic [7:0] GET_BASE  = 8'hD4;

endpackage

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode
  import mbox_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int LEN_W       = 8,
  parameter int DOM_W       = 2,
  parameter int NUM_DOM     = 2,
  parameter int SEND_RD_LEN = 1,
  parameter int SEND_WR_LEN = 7,
  parameter int GET_RD_LEN  = 5,
  parameter int GET_WR_LEN  = 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic [LEN_W-1:0]  wr_len,
  output cmd_kind_e         kind
);

  localparam int OP_W = CODE_W - DOM_W;
  localparam logic [OP_W-1:0] SEND_OP = OP_W'(SEND_BASE >> DOM_W);
  localparam logic [OP_W-1:0] GET_OP  = OP_W'(GET_BASE >> DOM_W);

  logic [NUM_DOM-1:0] dom_hit;
  logic [OP_W-1:0]    op;
  logic               dom_ok;
  logic               send_len_ok;
  logic               get_len_ok;

  // Each supported domain owns one bit of the domain field.
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign dom_hit[d] = (code[DOM_W-1:0] == DOM_W'(1 << d));
  end

  assign op          = code[CODE_W-1:DOM_W];
  assign dom_ok      = |dom_hit;
  assign send_len_ok = (rd_len == LEN_W'(SEND_RD_LEN)) && (wr_len == LEN_W'(SEND_WR_LEN));
  assign get_len_ok  = (rd_len == LEN_W'(GET_RD_LEN))  && (wr_len == LEN_W'(GET_WR_LEN));

  always_comb begin
    kind = CK_BAD;
    if (dom_ok) begin
      if (op == SEND_OP && send_len_ok) kind = CK_SEND;
      else if (op == GET_OP && get_len_ok) kind = CK_GET;
    end
  end

endmodule

// File: rtl/mbox_timer.sv
module mbox_timer #(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic hold,
  output logic expire
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && !hold && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
    end else if (!hold && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int DATA_W = 32,
  parameter int DOM_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DOM_W-1:0]  load_dom,
  input  logic              collect,
  input  logic              expire,
  input  logic              done,
  input  logic [DATA_W-1:0] result,
  output logic              pending,
  output logic              ready,
  output logic [DOM_W-1:0]  owner,
  output logic [DATA_W-1:0] data
);

  logic capture;

  assign capture = done && pending && !ready && !load && !collect && !expire;

  // Priority: new send, then collection or discard, then worker result.
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      ready   <= 1'b0;
      owner   <= '0;
    end else if (load) begin
      pending <= 1'b1;
      ready   <= 1'b0;
      owner   <= load_dom;
    end else if (collect || expire) begin
      pending <= 1'b0;
      ready   <= 1'b0;
    end else if (capture) begin
      ready   <= 1'b1;
    end
  end

  // Result storage has no reset; it is only read while ready is set.
  always_ff @(posedge clk) begin
    if (capture) data <= result;
  end

endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
  import mbox_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CODE_W      = 8,
  parameter int LEN_W       = 8,
  parameter int DOM_W       = 2,
  parameter int NUM_DOM     = 2,
  parameter int TIMEOUT_CYC = 100000,
  parameter int SEND_RD_LEN = 1,
  parameter int SEND_WR_LEN = 7,
  parameter int GET_RD_LEN  = 5,
  parameter int GET_WR_LEN  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              timeout_disable,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [LEN_W-1:0]  cmd_rd_len,
  input  logic [LEN_W-1:0]  cmd_wr_len,
  input  logic [DATA_W-1:0] cmd_payload,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_data,
  output logic              work_start,
  output logic [DATA_W-1:0] work_req,
  input  logic              work_done,
  input  logic [DATA_W-1:0] work_result
);

  cmd_kind_e         kind;
  logic              send_acc;
  logic              is_get;
  logic              dom_match;
  logic              get_ok;
  logic              expire;
  logic              pend_q;
  logic              ready_q;
  logic [DOM_W-1:0]  owner_q;
  logic [DATA_W-1:0] slot_data;
  rsp_status_e       status_d;
  logic [DATA_W-1:0] data_d;

  mbox_cmd_decode #(
    .CODE_W(CODE_W), .LEN_W(LEN_W), .DOM_W(DOM_W), .NUM_DOM(NUM_DOM),
    .SEND_RD_LEN(SEND_RD_LEN), .SEND_WR_LEN(SEND_WR_LEN),
    .GET_RD_LEN(GET_RD_LEN), .GET_WR_LEN(GET_WR_LEN)
  ) dec_i (
    .code(cmd_code), .rd_len(cmd_rd_len), .wr_len(cmd_wr_len), .kind(kind)
  );

  assign send_acc  = cmd_valid && (kind == CK_SEND);
  assign is_get    = cmd_valid && (kind == CK_GET);
  assign dom_match = pend_q && (owner_q == cmd_code[DOM_W-1:0]);
  assign get_ok    = is_get && dom_match && ready_q;

  mbox_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmr_i (
    .clk(clk), .rst(rst), .run(pend_q), .restart(send_acc),
    .hold(timeout_disable), .expire(expire)
  );

  mbox_slot #(.DATA_W(DATA_W), .DOM_W(DOM_W)) slot_i (
    .clk(clk), .rst(rst), .load(send_acc), .load_dom(cmd_code[DOM_W-1:0]),
    .collect(get_ok), .expire(expire), .done(work_done), .result(work_result),
    .pending(pend_q), .ready(ready_q), .owner(owner_q), .data(slot_data)
  );

  always_comb begin
    status_d = ST_ABORT;
    data_d   = '0;
    if (send_acc) begin
      status_d = ST_OK;
    end else if (is_get) begin
      if (!dom_match) begin
        status_d = ST_FAIL;
      end else if (!ready_q) begin
        status_d = ST_ABORT;
      end else begin
        status_d = ST_OK;
        data_d   = slot_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      work_start <= 1'b0;
    end else begin
      rsp_valid  <= cmd_valid;
      work_start <= send_acc;
    end
  end

  always_ff @(posedge clk) begin
    rsp_status <= status_d;
    rsp_data   <= data_d;
    if (send_acc) work_req <= cmd_payload;
  end

endmodule

// File: rtl/mbox_responder_chk.sv
module mbox_responder_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              timeout_disable,
  input logic              pending,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [DATA_W-1:0] rsp_data,
  input logic              work_start
);

  assert_rsp_after_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cmd_valid));

  assert_cmd_answered_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);

  assert_status_legal_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'd3));

  assert_data_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_data == '0));

  assert_start_with_ok_R3: assert property (@(posedge clk) disable iff (rst)
    work_start |-> (rsp_valid && rsp_status == 2'd0 && $past(cmd_valid)));

  assert_no_discard_R8: assert property (@(posedge clk) disable iff (rst)
    (pending && timeout_disable && !cmd_valid) |=> pending);

  assert_reset_empty_R11: assert property (@(posedge clk)
    rst |=> (!pending && !rsp_valid && !work_start));

endmodule

bind mbox_responder mbox_responder_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .timeout_disable(timeout_disable),
  .pending(pend_q), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_data(rsp_data), .work_start(work_start)
);

// File: tb/mbox_responder_tb_top.sv
module mbox_responder_tb_top;

  localparam int T  = 20;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tdis = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_code = '0;
  logic [7:0]    cmd_rd_len = '0;
  logic [7:0]    cmd_wr_len = '0;
  logic [DW-1:0] cmd_payload = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_data;
  logic          work_start;
  logic [DW-1:0] work_req;
  logic          work_done = 1'b0;
  logic [DW-1:0] work_result = '0;

  always #10 clk = ~clk;

  mbox_responder #(.DATA_W(DW), .TIMEOUT_CYC(T)) dut_i (
    .clk(clk), .rst(rst), .timeout_disable(tdis), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_rd_len(cmd_rd_len), .cmd_wr_len(cmd_wr_len),
    .cmd_payload(cmd_payload), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .work_start(work_start), .work_req(work_req),
    .work_done(work_done), .work_result(work_result)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference state
  bit          m_pend, m_ready;
  logic [1:0]  m_dom;
  logic [DW-1:0] m_data;
  int          m_cnt;
  // Worker model
  int          wcnt = 0;
  int          lat = 1;
  logic [DW-1:0] wreq = '0;

  function automatic logic [DW-1:0] work_fn(input logic [DW-1:0] r);
    return {r[15:0], r[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_pend = 0; m_ready = 0; m_cnt = 0; m_dom = '0; wcnt = 0;
  endtask

  // One clock cycle; called at a negedge, returns at the next negedge.
  task automatic cyc(input bit v, input logic [7:0] code, input logic [7:0] rd,
                     input logic [7:0] wr, input logic [DW-1:0] d, input string tag);
    bit dn;
    logic [DW-1:0] res;
    bit is_s, is_g, dom_ok, send_ok, get_ok;
    logic [1:0] e_st;
    logic [DW-1:0] e_data;
    dn = 0; res = '0;
    if (wcnt > 0) begin
      wcnt--;
      if (wcnt == 0) begin dn = 1; res = work_fn(wreq); end
    end
    work_done = dn; work_result = res;
    cmd_valid = v; cmd_code = code; cmd_rd_len = rd; cmd_wr_len = wr; cmd_payload = d;
    dom_ok = (code[1:0] == 2'b01) || (code[1:0] == 2'b10);
    is_s = v && dom_ok && code[7:2] == 6'h34 && rd == 8'd1 && wr == 8'd7;
    is_g = v && dom_ok && code[7:2] == 6'h35 && rd == 8'd5 && wr == 8'd1;
    send_ok = is_s; get_ok = 0; e_st = 2'd1; e_data = '0;
    if (is_s) e_st = 2'd0;
    else if (is_g) begin
      if (!m_pend || m_dom != code[1:0]) e_st = 2'd2;
      else if (!m_ready) e_st = 2'd1;
      else begin e_st = 2'd0; e_data = m_data; get_ok = 1; end
    end
    @(negedge clk);
    chk(rsp_valid == v, "R10", "rsp_valid", DW'(rsp_valid), DW'(v));
    if (v) begin
      chk(rsp_status == e_st, tag, "status", DW'(rsp_status), DW'(e_st));
      chk(rsp_data == e_data, tag, "data", rsp_data, e_data);
    end
    chk(work_start == send_ok, "R3", "work_start", DW'(work_start), DW'(send_ok));
    if (send_ok) chk(work_req == d, "R3", "work_req", work_req, d);
    if (work_start) begin wcnt = lat; wreq = work_req; end
    // next reference state
    if (send_ok) begin
      m_pend = 1; m_ready = 0; m_cnt = 0; m_dom = code[1:0];
    end else if (get_ok) begin
      m_pend = 0; m_ready = 0; m_cnt = 0;
    end else if (m_pend && !tdis && m_cnt == T - 1) begin
      m_pend = 0; m_ready = 0; m_cnt = 0;
    end else begin
      if (m_pend && !tdis) m_cnt++;
      if (m_pend && !m_ready && dn) begin m_ready = 1; m_data = res; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 8'h00, 8'h00, '0, "R10");
  endtask

  task automatic send(input logic [7:0] code, input logic [DW-1:0] d, input int l, input string tag);
    lat = l;
    cyc(1, code, 8'd1, 8'd7, d, tag);
  endtask

  task automatic get(input logic [7:0] code, input string tag);
    cyc(1, code, 8'd5, 8'd1, '0, tag);
  endtask

  task automatic do_reset();
    cmd_valid = 0; work_done = 0; rst = 1;
    repeat (3) @(negedge clk);
    model_clear();
    chk(rsp_valid == 0, "R11", "rsp_valid in reset", DW'(rsp_valid), '0);
    chk(work_start == 0, "R11", "work_start in reset", DW'(work_start), '0);
    rst = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    model_clear();
    @(negedge clk);
    do_reset();

    // R11 / R6: empty after reset, get has nothing to collect
    get(8'hD5, "R11");
    get(8'hD5, "R6");
    // R3 / R5 / R6 / R4
    send(8'hD1, 32'h1234_5678, 3, "R3");
    get(8'hD5, "R5");
    idle(3);
    get(8'hD6, "R6");
    get(8'hD5, "R4");
    get(8'hD5, "R4");
    // R1: unknown codes and domains
    cyc(1, 8'h55, 8'd5, 8'd1, '0, "R1");
    cyc(1, 8'hD3, 8'd1, 8'd7, 32'h1, "R1");
    cyc(1, 8'hD4, 8'd5, 8'd1, '0, "R1");
    // R2: bad lengths change nothing
    cyc(1, 8'hD2, 8'd1, 8'd6, 32'h2, "R2");
    cyc(1, 8'hD6, 8'd4, 8'd1, '0, "R2");
    get(8'hD6, "R2");
    // R1: domain 1 flow
    send(8'hD2, 32'hCAFE_0001, 1, "R1");
    idle(2);
    get(8'hD5, "R1");
    get(8'hD6, "R1");
    // R7: boundary edge still finds the request
    send(8'hD1, 32'hAAAA_0007, 1, "R7");
    idle(T - 1);
    get(8'hD5, "R7");
    // R7: one edge later it is gone
    send(8'hD1, 32'hBBBB_0007, 1, "R7");
    idle(T);
    get(8'hD5, "R7");
    // R8: disabled timeout keeps the request
    tdis = 1;
    send(8'hD2, 32'h0808_0808, 2, "R8");
    idle(3 * T);
    get(8'hD6, "R8");
    tdis = 0;
    // R9: overwrite restarts count and replaces data
    send(8'hD1, 32'h0909_0001, 1, "R9");
    idle(T - 5);
    send(8'hD1, 32'h0909_0002, 1, "R9");
    idle(T - 1);
    get(8'hD5, "R9");
    // R11: reset in the middle discards a pending request
    send(8'hD1, 32'h1111_1111, 1, "R11");
    idle(2);
    do_reset();
    get(8'hD5, "R11");

    // Random traffic
    for (int i = 0; i < 5000; i++) begin
      int r;
      logic [7:0] dc;
      r = int'($urandom % 100);
      dc = ($urandom % 2 == 0) ? 8'h01 : 8'h02;
      if ($urandom % 200 == 0) tdis = ~tdis;
      if (r < 25) begin
        lat = 1 + int'($urandom % 8);
        cyc(1, 8'hD0 | dc, ($urandom % 10 == 0) ? 8'($urandom % 3) : 8'd1,
            ($urandom % 10 == 0) ? 8'($urandom % 9) : 8'd7, $urandom, "R9");
      end else if (r < 65) begin
        cyc(1, 8'hD4 | dc, ($urandom % 10 == 0) ? 8'($urandom % 7) : 8'd5,
            8'd1, '0, "R5");
      end else if (r < 75) begin
        cyc(1, 8'($urandom), 8'($urandom % 8), 8'($urandom % 8), $urandom, "R1");
      end else begin
        idle(1 + int'($urandom % 6));
      end
    end
    tdis = 0;
    idle(2);
    finish_run();
  end

endmodule